// File: doc/BRIEF.md
# Vector-Length Control Register Access Arbiter

This block decides what happens to a move-to or move-from system register instruction that names the scalable-vector length control register of the operating-system level. The register can be reached through two encodings. The primary encoding has op1 = 0b000. The alias encoding has op1 = 0b101, and the other encoding fields are the same for both. The block receives the current exception level, the encoding selector, the hypervisor host-mode flag, the three nested-virtualisation bits, the vector-enable trap controls of levels 1, 2 and 3, and the debug state. It returns exactly one result: undefined instruction, trap, redirect to a different register, redirect to a memory slot, or normal access.

Each exception level has a fixed chain of checks, and the first check that fires sets the result. A trap also carries a 2-bit target level and a 6-bit exception class. A memory redirect carries the slot offset. Reads and writes are decided the same way, so the block has no direction input. The result is registered and appears one clock after the request.

Top module: `vctl_acc_arbiter`

## Requirements
- R1: When `res_vld_o` is 1, exactly one of `undef_o`, `trap_o`, `redir_reg_o`, `redir_mem_o`, `allow_o` is 1, and the result belongs to the request presented one cycle earlier. When `res_vld_o` is 0, all five flags, `trap_lvl_o`, `trap_ec_o` and `mem_off_o` are 0. `trap_lvl_o` and `trap_ec_o` are 0 unless `trap_o` is 1. `mem_off_o` is 0 unless `redir_mem_o` is 1.
- R2: A request at level 0 (`cur_lvl_i` = 0) gives undefined under either encoding.
- R3: Halt priority applies at level 1 with the primary encoding, and at level 2 with the primary encoding or with the alias encoding while host mode is on. When `HALT_PRIO` = 1, `halted_i`, `el3_impl_i` and `sec_dbg_dis_i` are all 1, and `l3_en_i` = 0, the result is undefined, ahead of every other check at that level.
- R4: At level 1 with the primary encoding, `l1_en_i[0]` = 0 traps to level 1 with class 0x19. Bit 1 of every enable field has no effect.
- R5: The level-2 check applies at level 1 (primary encoding, `el2_en_i` = 1) and at level 2 (primary encoding). It traps to level 2 with class 0x19 when `host_mode_i` = 0 and `l2_tz_i` = 1, or when `host_mode_i` = 1 and `l2_en_i[0]` = 0.
- R6: At levels 1 and 2, once the earlier checks have passed, `el3_impl_i` = 1 with `l3_en_i` = 0 traps to level 3 with class 0x19. If `halted_i` and `sec_dbg_dis_i` are both 1, the result is undefined instead.
- R7: At level 1 with the primary encoding, when all traps have passed, `el2_en_i` = 1 and `nest_i` = 3'b111 redirect to memory at offset `MEM_OFF` (default 0x1E0).
- R8: At level 2 with the primary encoding, when all traps have passed, `host_mode_i` = 1 redirects to the level-2 vector control register. Otherwise the access is allowed.
- R9: At level 3 with the primary encoding, the only check is `l3_en_i`. A value of 0 traps to level 3 with class 0x19, and a value of 1 allows the access.
- R10: At level 1 with the alias encoding, `el2_en_i` = 1 with `nest_i` = 3'b101 redirects to memory at `MEM_OFF`. Otherwise `el2_en_i` = 1 with `nest_i[0]` = 1 traps to level 2 with class 0x18. Otherwise the access is undefined. `nest_i` is ordered {memory bit, second bit, base enable bit}.
- R11: With the alias encoding, level 2 gives undefined unless `host_mode_i` = 1. Level 3 gives undefined unless `el2_en_i`, `el2_a64_i` and `host_mode_i` are all 1. When these conditions hold, level 2 applies R3, then its own enable-field trap, then R6. Level 3 applies the R9 check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_vld_i | input | 1 | A request is present this cycle |
| cur_lvl_i | input | 2 | Current exception level, 0 to 3 |
| alias_sel_i | input | 1 | 1 = alias encoding (op1 = 0b101), 0 = primary encoding |
| el2_en_i | input | 1 | Level 2 is enabled in the current security state |
| el3_impl_i | input | 1 | Level 3 is implemented |
| el2_a64_i | input | 1 | Level 2 uses the 64-bit execution state |
| host_mode_i | input | 1 | Hypervisor host mode |
| nest_i | input | 3 | Nested-virtualisation bits, ordered {memory, second, base} |
| l1_en_i | input | 2 | Level-1 vector enable field; only bit 0 is used |
| l2_en_i | input | 2 | Level-2 vector enable field (host mode); only bit 0 is used |
| l2_tz_i | input | 1 | Level-2 vector trap bit (non-host mode) |
| l3_en_i | input | 1 | Level-3 vector enable; 0 traps |
| halted_i | input | 1 | Core is in halting debug |
| sec_dbg_dis_i | input | 1 | Secure debug disabled |
| res_vld_o | output | 1 | Result valid |
| undef_o | output | 1 | Undefined instruction |
| trap_o | output | 1 | Trap taken |
| trap_lvl_o | output | 2 | Trap target level |
| trap_ec_o | output | 6 | Trap exception class |
| redir_reg_o | output | 1 | Redirect to the level-2 vector control register |
| redir_mem_o | output | 1 | Redirect to the memory slot |
| mem_off_o | output | 12 | Memory slot offset |
| allow_o | output | 1 | Normal access |

## Verification
Each request gives exactly one result. That result is registered once and must be read in the cycle after the request is presented. The bench drives one request per cycle, just after a rising edge. It pushes the expected outcome into a queue at the moment it drives the request. The monitor pops and compares one entry each time it sees `res_vld_o` at the following falling edge, and a result therefore cannot be matched to the wrong request. Idle cycles inserted in the stream check that nothing is reported when no request was presented.

// File: rtl/vctl_acc_pkg.sv
package vctl_acc_pkg;

    typedef enum logic [2:0] {
        RES_UNDEF     = 3'd0,
        RES_TRAP      = 3'd1,
        RES_REDIR_REG = 3'd2,
        RES_REDIR_MEM = 3'd3,
        RES_ALLOW     = 3'd4
    } res_kind_e;

    typedef struct packed {
        res_kind_e   kind;
        logic [1:0]  lvl;
        logic [5:0]  ec;
    } verdict_t;

    typedef struct packed {
        logic        vld;
        logic        undef;
        logic        trap;
        logic        rreg;
        logic        rmem;
        logic        allow;
        logic [1:0]  lvl;
        logic [5:0]  ec;
    } res_state_t;

    localparam logic [1:0] LVL_USR = 2'd0;
    localparam logic [1:0] LVL_OS  = 2'd1;
    localparam logic [1:0] LVL_HYP = 2'd2;
    localparam logic [1:0] LVL_MON = 2'd3;

    function automatic verdict_t mk_verdict(res_kind_e kind, logic [1:0] lvl, logic [5:0] ec);
        verdict_t v;
        v.kind = kind;
        v.lvl  = lvl;
        v.ec   = ec;
        return v;
    endfunction

    function automatic logic halt_blocks(logic prio, logic halted, logic el3_impl,
                                         logic sdd, logic l3_en);
        return prio && halted && el3_impl && sdd && !l3_en;
    endfunction

endpackage

// File: rtl/vctl_prim_chain.sv
module vctl_prim_chain
    import vctl_acc_pkg::*;
#(
    parameter bit         HALT_PRIO = 1'b1,
    parameter logic [5:0] EC_VEC    = 6'h19
) (
    input  logic [1:0] lvl_i,
    input  logic       el2_en_i,
    input  logic       el3_impl_i,
    input  logic       host_i,
    input  logic [2:0] nest_i,
    input  logic       l1_en0_i,
    input  logic       l2_en0_i,
    input  logic       l2_tz_i,
    input  logic       l3_en_i,
    input  logic       halted_i,
    input  logic       sdd_i,
    output verdict_t   v_o
);
    logic early_undef;
    logic l2_block;
    logic l3_block;
    verdict_t l3_verdict;

    assign early_undef = halt_blocks(HALT_PRIO, halted_i, el3_impl_i, sdd_i, l3_en_i);
    assign l2_block    = host_i ? !l2_en0_i : l2_tz_i;
    assign l3_block    = el3_impl_i && !l3_en_i;
    assign l3_verdict  = (halted_i && sdd_i) ? mk_verdict(RES_UNDEF, 2'd0, 6'd0)
                                             : mk_verdict(RES_TRAP, LVL_MON, EC_VEC);

    always_comb begin
        v_o = mk_verdict(RES_ALLOW, 2'd0, 6'd0);
        unique case (lvl_i)
            LVL_USR: v_o = mk_verdict(RES_UNDEF, 2'd0, 6'd0);
            LVL_OS: begin
                if (early_undef)                       v_o = mk_verdict(RES_UNDEF, 2'd0, 6'd0);
                else if (!l1_en0_i)                    v_o = mk_verdict(RES_TRAP, LVL_OS, EC_VEC);
                else if (el2_en_i && l2_block)         v_o = mk_verdict(RES_TRAP, LVL_HYP, EC_VEC);
                else if (l3_block)                     v_o = l3_verdict;
                else if (el2_en_i && nest_i == 3'b111) v_o = mk_verdict(RES_REDIR_MEM, 2'd0, 6'd0);
                else                                   v_o = mk_verdict(RES_ALLOW, 2'd0, 6'd0);
            end
            LVL_HYP: begin
                if (early_undef)      v_o = mk_verdict(RES_UNDEF, 2'd0, 6'd0);
                else if (l2_block)    v_o = mk_verdict(RES_TRAP, LVL_HYP, EC_VEC);
                else if (l3_block)    v_o = l3_verdict;
                else if (host_i)      v_o = mk_verdict(RES_REDIR_REG, 2'd0, 6'd0);
                else                  v_o = mk_verdict(RES_ALLOW, 2'd0, 6'd0);
            end
            LVL_MON: begin
                if (!l3_en_i) v_o = mk_verdict(RES_TRAP, LVL_MON, EC_VEC);
                else          v_o = mk_verdict(RES_ALLOW, 2'd0, 6'd0);
            end
            default: v_o = mk_verdict(RES_UNDEF, 2'd0, 6'd0);
        endcase
    end
endmodule

// File: rtl/vctl_alias_chain.sv
module vctl_alias_chain
    import vctl_acc_pkg::*;
#(
    parameter bit         HALT_PRIO = 1'b1,
    parameter logic [5:0] EC_VEC    = 6'h19,
    parameter logic [5:0] EC_NEST   = 6'h18
) (
    input  logic [1:0] lvl_i,
    input  logic       el2_en_i,
    input  logic       el3_impl_i,
    input  logic       el2_a64_i,
    input  logic       host_i,
    input  logic [2:0] nest_i,
    input  logic       l2_en0_i,
    input  logic       l3_en_i,
    input  logic       halted_i,
    input  logic       sdd_i,
    output verdict_t   v_o
);
    logic early_undef;
    logic mon_ok;

    assign early_undef = halt_blocks(HALT_PRIO, halted_i, el3_impl_i, sdd_i, l3_en_i);
    assign mon_ok      = el2_en_i && el2_a64_i && host_i;

    always_comb begin
        v_o = mk_verdict(RES_UNDEF, 2'd0, 6'd0);
        unique case (lvl_i)
            LVL_USR: v_o = mk_verdict(RES_UNDEF, 2'd0, 6'd0);
            LVL_OS: begin
                if (el2_en_i && nest_i == 3'b101)  v_o = mk_verdict(RES_REDIR_MEM, 2'd0, 6'd0);
                else if (el2_en_i && nest_i[0])    v_o = mk_verdict(RES_TRAP, LVL_HYP, EC_NEST);
                else                               v_o = mk_verdict(RES_UNDEF, 2'd0, 6'd0);
            end
            LVL_HYP: begin
                if (!host_i)                       v_o = mk_verdict(RES_UNDEF, 2'd0, 6'd0);
                else if (early_undef)              v_o = mk_verdict(RES_UNDEF, 2'd0, 6'd0);
                else if (!l2_en0_i)                v_o = mk_verdict(RES_TRAP, LVL_HYP, EC_VEC);
                else if (el3_impl_i && !l3_en_i)
                    v_o = (halted_i && sdd_i) ? mk_verdict(RES_UNDEF, 2'd0, 6'd0)
                                              : mk_verdict(RES_TRAP, LVL_MON, EC_VEC);
                else                               v_o = mk_verdict(RES_ALLOW, 2'd0, 6'd0);
            end
            LVL_MON: begin
                if (!mon_ok)        v_o = mk_verdict(RES_UNDEF, 2'd0, 6'd0);
                else if (!l3_en_i)  v_o = mk_verdict(RES_TRAP, LVL_MON, EC_VEC);
                else                v_o = mk_verdict(RES_ALLOW, 2'd0, 6'd0);
            end
            default: v_o = mk_verdict(RES_UNDEF, 2'd0, 6'd0);
        endcase
    end
endmodule

// File: rtl/vctl_onehot_enc.sv
module vctl_onehot_enc
    import vctl_acc_pkg::*;
(
    input  verdict_t   v_i,
    output logic [4:0] flags_o
);
    localparam int NKIND = 5;

    for (genvar k = 0; k < NKIND; k++) begin : g_flag
        assign flags_o[k] = (v_i.kind == res_kind_e'(k));
    end
endmodule

// File: rtl/vctl_acc_arbiter.sv
module vctl_acc_arbiter
    import vctl_acc_pkg::*;
#(
    parameter bit          HALT_PRIO = 1'b1,
    parameter int          OFF_W     = 12,
    parameter logic [11:0] MEM_OFF   = 12'h1E0,
    parameter logic [5:0]  EC_VEC    = 6'h19,
    parameter logic [5:0]  EC_NEST   = 6'h18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_vld_i,
    input  logic [1:0]       cur_lvl_i,
    input  logic             alias_sel_i,
    input  logic             el2_en_i,
    input  logic             el3_impl_i,
    input  logic             el2_a64_i,
    input  logic             host_mode_i,
    input  logic [2:0]       nest_i,
    input  logic [1:0]       l1_en_i,
    input  logic [1:0]       l2_en_i,
    input  logic             l2_tz_i,
    input  logic             l3_en_i,
    input  logic             halted_i,
    input  logic             sec_dbg_dis_i,
    output logic             res_vld_o,
    output logic             undef_o,
    output logic             trap_o,
    output logic [1:0]       trap_lvl_o,
    output logic [5:0]       trap_ec_o,
    output logic             redir_reg_o,
    output logic             redir_mem_o,
    output logic [OFF_W-1:0] mem_off_o,
    output logic             allow_o
);
    localparam logic [OFF_W-1:0] OFF_VAL = OFF_W'(MEM_OFF);

    verdict_t   prim_v;
    verdict_t   alias_v;
    verdict_t   sel_v;
    logic [4:0] flags;
    res_state_t st_d;
    res_state_t st_q;
    logic       unused_hi;

    assign unused_hi = l1_en_i[1] ^ l2_en_i[1];

    vctl_prim_chain #(.HALT_PRIO(HALT_PRIO), .EC_VEC(EC_VEC)) u_prim (
        .lvl_i      (cur_lvl_i),
        .el2_en_i   (el2_en_i),
        .el3_impl_i (el3_impl_i),
        .host_i     (host_mode_i),
        .nest_i     (nest_i),
        .l1_en0_i   (l1_en_i[0]),
        .l2_en0_i   (l2_en_i[0]),
        .l2_tz_i    (l2_tz_i),
        .l3_en_i    (l3_en_i),
        .halted_i   (halted_i),
        .sdd_i      (sec_dbg_dis_i),
        .v_o        (prim_v)
    );

    vctl_alias_chain #(.HALT_PRIO(HALT_PRIO), .EC_VEC(EC_VEC), .EC_NEST(EC_NEST)) u_alias (
        .lvl_i      (cur_lvl_i),
        .el2_en_i   (el2_en_i),
        .el3_impl_i (el3_impl_i),
        .el2_a64_i  (el2_a64_i),
        .host_i     (host_mode_i),
        .nest_i     (nest_i),
        .l2_en0_i   (l2_en_i[0]),
        .l3_en_i    (l3_en_i),
        .halted_i   (halted_i),
        .sdd_i      (sec_dbg_dis_i),
        .v_o        (alias_v)
    );

    assign sel_v = alias_sel_i ? alias_v : prim_v;

    vctl_onehot_enc u_enc (
        .v_i     (sel_v),
        .flags_o (flags)
    );

    always_comb begin
        st_d = '0;
        if (acc_vld_i) begin
            st_d.vld   = 1'b1;
            st_d.undef = flags[RES_UNDEF];
            st_d.trap  = flags[RES_TRAP];
            st_d.rreg  = flags[RES_REDIR_REG];
            st_d.rmem  = flags[RES_REDIR_MEM];
            st_d.allow = flags[RES_ALLOW];
            if (flags[RES_TRAP]) begin
                st_d.lvl = sel_v.lvl;
                st_d.ec  = sel_v.ec;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_vld_o   = st_q.vld;
    assign undef_o     = st_q.undef;
    assign trap_o      = st_q.trap;
    assign trap_lvl_o  = st_q.lvl;
    assign trap_ec_o   = st_q.ec;
    assign redir_reg_o = st_q.rreg;
    assign redir_mem_o = st_q.rmem;
    assign mem_off_o   = st_q.rmem ? OFF_VAL : '0;
    assign allow_o     = st_q.allow;
endmodule

// File: rtl/vctl_acc_chk.sv
module vctl_acc_chk #(
    parameter logic [5:0] EC_VEC  = 6'h19,
    parameter logic [5:0] EC_NEST = 6'h18
) (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_vld_i,
    input logic [1:0] cur_lvl_i,
    input logic       alias_sel_i,
    input logic       el2_en_i,
    input logic       host_mode_i,
    input logic       l3_en_i,
    input logic       res_vld_o,
    input logic       undef_o,
    input logic       trap_o,
    input logic [1:0] trap_lvl_o,
    input logic [5:0] trap_ec_o,
    input logic       redir_reg_o,
    input logic       redir_mem_o,
    input logic       allow_o
);
    assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld_o |-> $countones({undef_o, trap_o, redir_reg_o, redir_mem_o, allow_o}) == 1);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld_o |-> ({undef_o, trap_o, redir_reg_o, redir_mem_o, allow_o} == 5'd0));

    assert_trap_fields_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_o |-> (trap_lvl_o == 2'd0 && trap_ec_o == 6'd0));

    assert_trap_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (trap_ec_o == EC_VEC || trap_ec_o == EC_NEST) && trap_lvl_o != 2'd0);

    assert_usr_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld_i && cur_lvl_i == 2'd0) |=> undef_o);

    assert_mon_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld_i && cur_lvl_i == 2'd3 && !alias_sel_i && l3_en_i) |=> allow_o);

    assert_alias_os_undef_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld_i && cur_lvl_i == 2'd1 && alias_sel_i && !el2_en_i) |=> undef_o);

    assert_alias_hyp_guest_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld_i && cur_lvl_i == 2'd2 && alias_sel_i && !host_mode_i) |=> undef_o);
endmodule

bind vctl_acc_arbiter vctl_acc_chk #(.EC_VEC(EC_VEC), .EC_NEST(EC_NEST)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_vld_i   (acc_vld_i),
    .cur_lvl_i   (cur_lvl_i),
    .alias_sel_i (alias_sel_i),
    .el2_en_i    (el2_en_i),
    .host_mode_i (host_mode_i),
    .l3_en_i     (l3_en_i),
    .res_vld_o   (res_vld_o),
    .undef_o     (undef_o),
    .trap_o      (trap_o),
    .trap_lvl_o  (trap_lvl_o),
    .trap_ec_o   (trap_ec_o),
    .redir_reg_o (redir_reg_o),
    .redir_mem_o (redir_mem_o),
    .allow_o     (allow_o)
);

// File: tb/test_vctl_acc_arbiter.sv
module test_vctl_acc_arbiter;
    localparam time CLK_PERIOD = 10ns;
    localparam int  N_VEC      = 65536;
    localparam int  WATCHDOG   = 150000;

    typedef struct packed {
        logic [3:0]  rule;
        logic        undef;
        logic        trap;
        logic        rreg;
        logic        rmem;
        logic        allow;
        logic [1:0]  lvl;
        logic [5:0]  ec;
        logic [11:0] off;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_vld_i = 1'b0;
    logic [1:0] cur_lvl_i = '0;
    logic alias_sel_i = 1'b0, el2_en_i = 1'b0, el3_impl_i = 1'b0, el2_a64_i = 1'b0;
    logic host_mode_i = 1'b0;
    logic [2:0] nest_i = '0;
    logic [1:0] l1_en_i = '0, l2_en_i = '0;
    logic l2_tz_i = 1'b0, l3_en_i = 1'b0, halted_i = 1'b0, sec_dbg_dis_i = 1'b0;
    logic res_vld_o, undef_o, trap_o, redir_reg_o, redir_mem_o, allow_o;
    logic [1:0] trap_lvl_o;
    logic [5:0] trap_ec_o;
    logic [11:0] mem_off_o;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;
    exp_t expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    vctl_acc_arbiter i_vctl_acc_arbiter (.*);

    function automatic string rule_tag(logic [3:0] r);
        case (r)
            4'd1:  return "R1";
            4'd2:  return "R2";
            4'd3:  return "R3";
            4'd4:  return "R4";
            4'd5:  return "R5";
            4'd6:  return "R6";
            4'd7:  return "R7";
            4'd8:  return "R8";
            4'd9:  return "R9";
            4'd10: return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic exp_t mk(logic [3:0] rule, int kind, logic [1:0] lvl, logic [5:0] ec);
        exp_t e = '0;
        e.rule = rule;
        case (kind)
            0: e.undef = 1'b1;
            1: begin e.trap = 1'b1; e.lvl = lvl; e.ec = ec; end
            2: e.rreg = 1'b1;
            3: begin e.rmem = 1'b1; e.off = 12'h1E0; end
            default: e.allow = 1'b1;
        endcase
        return e;
    endfunction

    // Reference outcome built from the requirement list
    function automatic exp_t ref_model(logic [15:0] x);
        logic [1:0] lv = x[1:0];
        logic al = x[2], e2 = x[3], e3 = x[4], a64 = x[5], hm = x[6];
        logic [2:0] nb = x[9:7];
        logic en1 = x[10], en2 = x[11], tz = x[12], ez = x[13], hl = x[14], sd = x[15];
        logic halt_pri = hl && e3 && sd && !ez;
        logic hyp_blk = hm ? !en2 : tz;
        if (lv == 2'd0) return mk(4'd2, 0, 0, 0);
        if (!al) begin
            if (lv == 2'd3) return ez ? mk(4'd9, 4, 0, 0) : mk(4'd9, 1, 2'd3, 6'h19);
            if (halt_pri) return mk(4'd3, 0, 0, 0);
            if (lv == 2'd1 && !en1) return mk(4'd4, 1, 2'd1, 6'h19);
            if ((lv == 2'd2 || e2) && hyp_blk) return mk(4'd5, 1, 2'd2, 6'h19);
            if (e3 && !ez) return (hl && sd) ? mk(4'd6, 0, 0, 0) : mk(4'd6, 1, 2'd3, 6'h19);
            if (lv == 2'd1) return (e2 && nb == 3'b111) ? mk(4'd7, 3, 0, 0) : mk(4'd7, 4, 0, 0);
            return hm ? mk(4'd8, 2, 0, 0) : mk(4'd8, 4, 0, 0);
        end
        if (lv == 2'd1) begin
            if (e2 && nb == 3'b101) return mk(4'd10, 3, 0, 0);
            if (e2 && nb[0]) return mk(4'd10, 1, 2'd2, 6'h18);
            return mk(4'd10, 0, 0, 0);
        end
        if (lv == 2'd2) begin
            if (!hm) return mk(4'd11, 0, 0, 0);
            if (halt_pri) return mk(4'd3, 0, 0, 0);
            if (!en2) return mk(4'd11, 1, 2'd2, 6'h19);
            if (e3 && !ez) return (hl && sd) ? mk(4'd6, 0, 0, 0) : mk(4'd6, 1, 2'd3, 6'h19);
            return mk(4'd11, 4, 0, 0);
        end
        if (!(e2 && a64 && hm)) return mk(4'd11, 0, 0, 0);
        return ez ? mk(4'd11, 4, 0, 0) : mk(4'd11, 1, 2'd3, 6'h19);
    endfunction

    function automatic logic [24:0] pack_dut();
        return {undef_o, trap_o, redir_reg_o, redir_mem_o, allow_o, trap_lvl_o, trap_ec_o, mem_off_o};
    endfunction

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic drive(logic [15:0] x);
        @(posedge clk);
        #1;
        acc_vld_i     = 1'b1;
        cur_lvl_i     = x[1:0];
        alias_sel_i   = x[2];
        el2_en_i      = x[3];
        el3_impl_i    = x[4];
        el2_a64_i     = x[5];
        host_mode_i   = x[6];
        nest_i        = x[9:7];
        l1_en_i       = {^x[7:0], x[10]};      // R4: high bit varied, must not matter
        l2_en_i       = {x[3] ^ x[12], x[11]};
        l2_tz_i       = x[12];
        l3_en_i       = x[13];
        halted_i      = x[14];
        sec_dbg_dis_i = x[15];
        expq.push_back(ref_model(x));
    endtask

    task automatic idle_cycle();
        @(posedge clk);
        #1;
        acc_vld_i = 1'b0;
    endtask

    // Monitor: compares at falling edges, one cycle after the request
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (res_vld_o) begin
                exp_t e;
                logic [24:0] want;
                if (expq.size() == 0) begin
                    n_cmp++; n_bad++;
                    $display("FAIL R1: result with no request, act=%h exp=none", pack_dut());
                end else begin
                    e = expq.pop_front();
                    want = {e.undef, e.trap, e.rreg, e.rmem, e.allow, e.lvl, e.ec, e.off};
                    n_cmp++;
                    if (pack_dut() !== want) begin
                        n_bad++;
                        $display("FAIL %s: act=%h exp=%h", rule_tag(e.rule), pack_dut(), want);
                    end
                end
            end else begin
                n_cmp++;
                if (pack_dut() !== 25'd0) begin
                    n_bad++;
                    $display("FAIL R1: idle outputs act=%h exp=0", pack_dut());
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL R1: watchdog expired act=%0d cycles exp<=%0d", cycles, WATCHDOG);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // Reset state (R1) is covered by the idle check at the next falling edge
        idle_cycle();
        for (int i = 0; i < N_VEC; i++) begin
            drive(16'(i));
            if ((i % 4096) == 4095) idle_cycle();
        end
        idle_cycle();
        idle_cycle();
        done = 1'b1;
        n_cmp++;
        if (expq.size() != 0) begin
            n_bad++;
            $display("FAIL R1: pending results act=%0d exp=0", expq.size());
        end
        finish_run();
    end
endmodule